// File: doc/BRIEF.md
# Superpage-Capable Fully Associative Translation Cache

This block caches recent virtual-to-physical page translations for one requester. A lookup presents a virtual address, an address-space tag and an access kind. In the same cycle the virtual page number is compared against every occupied slot. The lookup then returns exactly one outcome: a hit with a physical address, a miss that asks for a refill, or a fault that asks for a trap. The physical address keeps the untranslated offset bits of the virtual address and replaces the page bits with the stored physical page.

Each slot records:
- a page tag and an address-space tag;
- a physical page;
- a size exponent n, so that one slot covers 2^n aligned, contiguous 4 KB base pages;
- a translation-valid bit and a two-bit permission code;
- referenced and modified flags, which the block maintains itself.

A refill port loads one slot. It picks the lowest empty slot, or a round-robin victim when every slot is occupied. A full flush clears every slot. An address-space flush clears only the slots that carry a given tag. A read-back port shows the contents of any slot.

Top module: `tlb_sp`

## Requirements
- R1: After reset every slot is empty, and every lookup reports a miss with a physical address of zero.
- R2: A lookup whose page and address-space tag both match an occupied slot that is translation-valid and permits the access reports a hit. Its physical address is the stored physical page joined with the 12 offset bits of the virtual address.
- R3: A slot never matches a lookup that carries a different address-space tag; such a lookup reports a miss unless another slot matches.
- R4: For a slot of size n (0..7), the low n page bits are left out of the compare and are copied from the virtual address into the physical address. The low n bits of the stored page tag and of the stored physical page have no effect.
- R5: Access kinds are 0 read, 1 write and 2 execute. Permission codes are 0 read-only, 1 execute-only, 2 read-write (read and write, no execute) and 3 no access. A matching access that its code does not allow reports a fault with a physical address of zero.
- R6: A matching slot whose translation-valid bit is 0 reports a fault and produces no address.
- R7: A hit sets the referenced flag of the slot it used, and a write hit also sets that slot's modified flag. A fault changes neither flag. Both flags can be read back.
- R8: A refill goes to the lowest-numbered empty slot. When no slot is empty, it goes to a round-robin pointer that starts at slot 0 after reset and moves on by one slot (wrapping) after each refill that uses it. A refilled slot starts with both flags clear.
- R9: A full flush empties every slot on the next edge, and a refill in the same cycle is discarded.
- R10: An address-space flush empties only the slots whose address-space tag equals the given tag; a refill in the same cycle is discarded.
- R11: When several slots match, the lowest-numbered one decides the outcome and the address, and the multi-match flag is raised.
- R12: With no lookup request, hit, miss, fault and multi-match are all low; with a request, exactly one of hit, miss and fault is high.
- R13: When a refill lands in the same cycle on the slot that the lookup hits, the lookup is answered from the old contents. The slot then holds the refilled translation with both flags clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_va | input | VA_W | Virtual address to translate |
| lk_asid | input | ASID_W | Address-space tag of the lookup |
| lk_acc | input | 2 | Access kind (0 read, 1 write, 2 execute) |
| lk_hit | output | 1 | Translation found and permitted |
| lk_miss | output | 1 | No slot matches; refill needed |
| lk_fault | output | 1 | Match without valid translation or permission |
| lk_multi | output | 1 | More than one slot matched |
| lk_pa | output | PA_W | Physical address on a hit, zero otherwise |
| wr_en | input | 1 | Refill strobe |
| wr_vpn | input | VA_W-12 | Refill page tag |
| wr_asid | input | ASID_W | Refill address-space tag |
| wr_ppn | input | PA_W-12 | Refill physical page |
| wr_size | input | SIZE_W | Refill size exponent |
| wr_valid | input | 1 | Refill translation-valid bit |
| wr_prot | input | 2 | Refill permission code |
| flush_all | input | 1 | Empty every slot |
| flush_asid_en | input | 1 | Empty the slots of one address space |
| flush_asid_id | input | ASID_W | Address-space tag to flush |
| rd_idx | input | log2(ENTRIES) | Slot selected for read-back |
| rd_inuse | output | 1 | Selected slot occupied |
| rd_vpn | output | VA_W-12 | Selected slot page tag |
| rd_asid | output | ASID_W | Selected slot address-space tag |
| rd_ppn | output | PA_W-12 | Selected slot physical page |
| rd_size | output | SIZE_W | Selected slot size exponent |
| rd_ref | output | 1 | Selected slot referenced flag |
| rd_mod | output | 1 | Selected slot modified flag |

## Verification
A lookup that hits and a refill whose victim is that same slot can occur in one cycle. Flag maintenance and slot replacement then both target the slot on the same edge. The bench fills every slot so that the round-robin pointer names a known slot, then presents a hit on that slot together with a refill. It expects the old physical address in that cycle. Afterwards it reads back the new page tag with both flags clear, which shows that the refill took precedence over the flag update.

// File: rtl/tlb_sp_pkg.sv
`timescale 1ns/1ps
package tlb_sp_pkg;

   localparam logic [1:0] ACC_READ  = 2'd0;
   localparam logic [1:0] ACC_WRITE = 2'd1;
   localparam logic [1:0] ACC_EXEC  = 2'd2;

   localparam logic [1:0] PR_RDONLY = 2'd0;
   localparam logic [1:0] PR_XONLY  = 2'd1;
   localparam logic [1:0] PR_RDWR   = 2'd2;
   localparam logic [1:0] PR_NONE   = 2'd3;

   // permission code against access kind
   function automatic logic access_ok(input logic [1:0] prot, input logic [1:0] acc);
      logic ok;
      case (prot)
         PR_RDONLY: ok = (acc == ACC_READ);
         PR_XONLY:  ok = (acc == ACC_EXEC);
         PR_RDWR:   ok = (acc == ACC_READ) || (acc == ACC_WRITE);
         default:   ok = 1'b0;
      endcase
      return ok;
   endfunction

endpackage

// File: rtl/tlb_sp_lowidx.sv
`timescale 1ns/1ps
module tlb_sp_lowidx #(
   parameter int N     = 16,
   parameter int IDX_W = 4
) (
   input  logic [N-1:0]     vec,
   output logic [IDX_W-1:0] idx,
   output logic             any
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) idx = IDX_W'(i);
      end
   end
   assign any = |vec;
endmodule

// File: rtl/tlb_sp_match.sv
`timescale 1ns/1ps
module tlb_sp_match #(
   parameter int ENTRIES = 16,
   parameter int VPN_W   = 20,
   parameter int ASID_W  = 8,
   parameter int SIZE_W  = 3
) (
   input  logic [VPN_W-1:0]                 q_vpn,
   input  logic [ASID_W-1:0]                q_asid,
   input  logic [ENTRIES-1:0]               e_live,
   input  logic [ENTRIES-1:0][VPN_W-1:0]    e_vpn,
   input  logic [ENTRIES-1:0][ASID_W-1:0]   e_asid,
   input  logic [ENTRIES-1:0][SIZE_W-1:0]   e_size,
   output logic [ENTRIES-1:0]               hits
);
   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      logic [VPN_W-1:0] keep;
      // bits above the superpage span take part in the compare
      assign keep    = {VPN_W{1'b1}} << e_size[g];
      assign hits[g] = e_live[g] && (e_asid[g] == q_asid) &&
                       (((e_vpn[g] ^ q_vpn) & keep) == '0);
   end
endmodule

// File: rtl/tlb_sp_victim.sv
`timescale 1ns/1ps
module tlb_sp_victim #(
   parameter int ENTRIES = 16,
   parameter int IDX_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ENTRIES-1:0] inuse,
   input  logic               take,
   output logic [IDX_W-1:0]   slot
);
   logic [IDX_W-1:0] free_idx;
   logic             free_any;
   logic [IDX_W-1:0] rr_q;

   tlb_sp_lowidx #(.N(ENTRIES), .IDX_W(IDX_W)) u_free (
      .vec (~inuse),
      .idx (free_idx),
      .any (free_any)
   );

   assign slot = free_any ? free_idx : rr_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                  rr_q <= '0;
      else if (take && !free_any)  rr_q <= rr_q + 1'b1;
   end
endmodule

// File: rtl/tlb_sp.sv
`timescale 1ns/1ps
module tlb_sp #(
   parameter int ENTRIES = 16,
   parameter int VA_W    = 32,
   parameter int PA_W    = 32,
   parameter int OFF_W   = 12,
   parameter int ASID_W  = 8,
   parameter int SIZE_W  = 3,
   localparam int VPN_W  = VA_W - OFF_W,
   localparam int PPN_W  = PA_W - OFF_W,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_req,
   input  logic [VA_W-1:0]   lk_va,
   input  logic [ASID_W-1:0] lk_asid,
   input  logic [1:0]        lk_acc,
   output logic              lk_hit,
   output logic              lk_miss,
   output logic              lk_fault,
   output logic              lk_multi,
   output logic [PA_W-1:0]   lk_pa,
   input  logic              wr_en,
   input  logic [VPN_W-1:0]  wr_vpn,
   input  logic [ASID_W-1:0] wr_asid,
   input  logic [PPN_W-1:0]  wr_ppn,
   input  logic [SIZE_W-1:0] wr_size,
   input  logic              wr_valid,
   input  logic [1:0]        wr_prot,
   input  logic              flush_all,
   input  logic              flush_asid_en,
   input  logic [ASID_W-1:0] flush_asid_id,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              rd_inuse,
   output logic [VPN_W-1:0]  rd_vpn,
   output logic [ASID_W-1:0] rd_asid,
   output logic [PPN_W-1:0]  rd_ppn,
   output logic [SIZE_W-1:0] rd_size,
   output logic              rd_ref,
   output logic              rd_mod
);
   import tlb_sp_pkg::*;

   localparam int MAX_SPAN = (1 << SIZE_W) - 1;

   // elaboration checks
   if (ENTRIES < 2 || ENTRIES > 64 || (1 << IDX_W) != ENTRIES) begin : g_bad_entries
      $error("tlb_sp: ENTRIES must be a power of two in 2..64");
   end
   if (OFF_W < 1 || VPN_W < 1 || PPN_W < 1) begin : g_bad_widths
      $error("tlb_sp: address widths must exceed the offset width");
   end
   if (MAX_SPAN > VPN_W || MAX_SPAN > PPN_W) begin : g_bad_size
      $error("tlb_sp: SIZE_W allows spans wider than a page number");
   end

   // slot storage
   logic [ENTRIES-1:0]              inuse_q;
   logic [ENTRIES-1:0][VPN_W-1:0]   vpn_q;
   logic [ENTRIES-1:0][ASID_W-1:0]  asid_q;
   logic [ENTRIES-1:0][PPN_W-1:0]   ppn_q;
   logic [ENTRIES-1:0][SIZE_W-1:0]  size_q;
   logic [ENTRIES-1:0]              val_q;
   logic [ENTRIES-1:0][1:0]         prot_q;
   logic [ENTRIES-1:0]              ref_q;
   logic [ENTRIES-1:0]              mod_q;

   // lookup
   logic [VPN_W-1:0]   q_vpn;
   logic [ENTRIES-1:0] hits;
   logic [IDX_W-1:0]   sel;
   logic               any_hit;
   logic               many_hit;
   logic               sel_ok;
   logic [PPN_W-1:0]   span_mask;
   logic [PPN_W-1:0]   out_ppn;

   assign q_vpn = lk_va[VA_W-1:OFF_W];

   tlb_sp_match #(
      .ENTRIES (ENTRIES), .VPN_W (VPN_W), .ASID_W (ASID_W), .SIZE_W (SIZE_W)
   ) u_match (
      .q_vpn  (q_vpn),
      .q_asid (lk_asid),
      .e_live (inuse_q),
      .e_vpn  (vpn_q),
      .e_asid (asid_q),
      .e_size (size_q),
      .hits   (hits)
   );

   tlb_sp_lowidx #(.N(ENTRIES), .IDX_W(IDX_W)) u_pick (
      .vec (hits),
      .idx (sel),
      .any (any_hit)
   );

   assign many_hit  = (hits & (hits - 1'b1)) != '0;
   assign sel_ok    = val_q[sel] && access_ok(prot_q[sel], lk_acc);
   assign span_mask = ~({PPN_W{1'b1}} << size_q[sel]);
   assign out_ppn   = (ppn_q[sel] & ~span_mask) | (PPN_W'(q_vpn) & span_mask);

   assign lk_hit   = lk_req && any_hit && sel_ok;
   assign lk_fault = lk_req && any_hit && !sel_ok;
   assign lk_miss  = lk_req && !any_hit;
   assign lk_multi = lk_req && many_hit;
   assign lk_pa    = lk_hit ? {out_ppn, lk_va[OFF_W-1:0]} : '0;

   // refill placement
   logic             take;
   logic [IDX_W-1:0] wr_slot;

   assign take = wr_en && !flush_all && !flush_asid_en;

   tlb_sp_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
      .clk   (clk),
      .rst_n (rst_n),
      .inuse (inuse_q),
      .take  (take),
      .slot  (wr_slot)
   );

   // state update: flush, then flag update, then refill (last wins)
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         inuse_q <= '0;
         vpn_q   <= '0;
         asid_q  <= '0;
         ppn_q   <= '0;
         size_q  <= '0;
         val_q   <= '0;
         prot_q  <= '0;
         ref_q   <= '0;
         mod_q   <= '0;
      end else if (flush_all) begin
         inuse_q <= '0;
      end else begin
         if (flush_asid_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
               if (asid_q[i] == flush_asid_id) inuse_q[i] <= 1'b0;
            end
         end
         if (lk_hit) begin
            ref_q[sel] <= 1'b1;
            if (lk_acc == ACC_WRITE) mod_q[sel] <= 1'b1;
         end
         if (take) begin
            inuse_q[wr_slot] <= 1'b1;
            vpn_q[wr_slot]   <= wr_vpn;
            asid_q[wr_slot]  <= wr_asid;
            ppn_q[wr_slot]   <= wr_ppn;
            size_q[wr_slot]  <= wr_size;
            val_q[wr_slot]   <= wr_valid;
            prot_q[wr_slot]  <= wr_prot;
            ref_q[wr_slot]   <= 1'b0;
            mod_q[wr_slot]   <= 1'b0;
         end
      end
   end

   // read-back
   assign rd_inuse = inuse_q[rd_idx];
   assign rd_vpn   = vpn_q[rd_idx];
   assign rd_asid  = asid_q[rd_idx];
   assign rd_ppn   = ppn_q[rd_idx];
   assign rd_size  = size_q[rd_idx];
   assign rd_ref   = ref_q[rd_idx];
   assign rd_mod   = mod_q[rd_idx];

endmodule

// File: rtl/tlb_sp_chk.sv
`timescale 1ns/1ps
module tlb_sp_chk #(
   parameter int ENTRIES = 16,
   parameter int VA_W    = 32,
   parameter int PA_W    = 32,
   parameter int OFF_W   = 12
) (
   input logic               clk,
   input logic               rst_n,
   input logic               lk_req,
   input logic [VA_W-1:0]    lk_va,
   input logic               lk_hit,
   input logic               lk_miss,
   input logic               lk_fault,
   input logic               lk_multi,
   input logic [PA_W-1:0]    lk_pa,
   input logic               wr_en,
   input logic               flush_all,
   input logic               flush_asid_en,
   input logic [ENTRIES-1:0] inuse_q
);
   p_one_outcome_r12: assert property (@(posedge clk) disable iff (!rst_n)
      lk_req |-> $countones({lk_hit, lk_miss, lk_fault}) == 1);

   p_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_req |-> !(lk_hit || lk_miss || lk_fault || lk_multi));

   p_offset_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> lk_pa[OFF_W-1:0] == lk_va[OFF_W-1:0]);

   p_no_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_req && !lk_hit) |-> lk_pa == '0);

   p_multi_match_r11: assert property (@(posedge clk) disable iff (!rst_n)
      lk_multi |-> !lk_miss);

   p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flush_all |=> inuse_q == '0);

   p_refill_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !flush_all && !flush_asid_en) |=> inuse_q != '0);
endmodule

bind tlb_sp tlb_sp_chk #(
   .ENTRIES (ENTRIES), .VA_W (VA_W), .PA_W (PA_W), .OFF_W (OFF_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .lk_req        (lk_req),
   .lk_va         (lk_va),
   .lk_hit        (lk_hit),
   .lk_miss       (lk_miss),
   .lk_fault      (lk_fault),
   .lk_multi      (lk_multi),
   .lk_pa         (lk_pa),
   .wr_en         (wr_en),
   .flush_all     (flush_all),
   .flush_asid_en (flush_asid_en),
   .inuse_q       (inuse_q)
);

// File: tb/tb_tlb_sp.sv
`timescale 1ns/1ps
module tb_tlb_sp;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_req = 1'b0;
   logic [31:0] lk_va = '0;
   logic [7:0]  lk_asid = '0;
   logic [1:0]  lk_acc = '0;
   logic        lk_hit, lk_miss, lk_fault, lk_multi;
   logic [31:0] lk_pa;
   logic        wr_en = 1'b0;
   logic [19:0] wr_vpn = '0;
   logic [7:0]  wr_asid = '0;
   logic [19:0] wr_ppn = '0;
   logic [2:0]  wr_size = '0;
   logic        wr_valid = 1'b0;
   logic [1:0]  wr_prot = '0;
   logic        flush_all = 1'b0;
   logic        flush_asid_en = 1'b0;
   logic [7:0]  flush_asid_id = '0;
   logic [3:0]  rd_idx = '0;
   logic        rd_inuse;
   logic [19:0] rd_vpn;
   logic [7:0]  rd_asid;
   logic [19:0] rd_ppn;
   logic [2:0]  rd_size;
   logic        rd_ref, rd_mod;

   int checks = 0;
   int failures = 0;

   always #4 clk = ~clk;

   tlb_sp dut (.*);

   // outcome code {hit, miss, fault}
   localparam logic [2:0] O_HIT = 3'b100, O_MISS = 3'b010, O_FLT = 3'b001;

   typedef struct packed {
      logic [31:0] va;
      logic [7:0]  asid;
      logic [1:0]  acc;
      logic [2:0]  res;
      logic [31:0] pa;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VECS [NV] = '{
      '{32'h00010ABC, 8'd1, 2'd0, O_HIT,  32'h80240ABC},  // R2 read RW
      '{32'h00010ABC, 8'd3, 2'd1, O_HIT,  32'h00600ABC},  // R3 other space, write
      '{32'h00010ABC, 8'd2, 2'd0, O_MISS, 32'h0},         // R3 no such space
      '{32'h00020123, 8'd1, 2'd0, O_HIT,  32'h00300123},  // R5 read RO
      '{32'h00020123, 8'd1, 2'd1, O_FLT,  32'h0},         // R5 write RO
      '{32'h00030FFF, 8'd1, 2'd2, O_HIT,  32'h00400FFF},  // R5 exec XO
      '{32'h00030FFF, 8'd1, 2'd0, O_FLT,  32'h0},         // R5 read XO
      '{32'h00006234, 8'd2, 2'd1, O_HIT,  32'h80242234},  // R4 superpage write
      '{32'h00007000, 8'd2, 2'd0, O_HIT,  32'h80243000},  // R4 top page of span
      '{32'h00008000, 8'd2, 2'd0, O_MISS, 32'h0},         // R4 above span
      '{32'h00040000, 8'd1, 2'd0, O_FLT,  32'h0},         // R6 invalid
      '{32'h00010000, 8'd1, 2'd2, O_FLT,  32'h0},         // R5 exec RW
      '{32'h00003FFF, 8'd2, 2'd0, O_MISS, 32'h0}          // R4 below span
   };

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic report();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   task automatic refill(input logic [19:0] vpn, input logic [7:0] asid, input logic [19:0] ppn,
                         input logic [2:0] sz, input logic v, input logic [1:0] prot);
      @(negedge clk);
      wr_vpn = vpn; wr_asid = asid; wr_ppn = ppn; wr_size = sz; wr_valid = v; wr_prot = prot;
      wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic lookup(input string tag, input logic [31:0] va, input logic [7:0] asid,
                         input logic [1:0] acc, input logic [2:0] res, input logic [31:0] pa);
      @(negedge clk);
      lk_va = va; lk_asid = asid; lk_acc = acc; lk_req = 1'b1;
      #2;
      chk({tag, " outcome"}, {61'd0, lk_hit, lk_miss, lk_fault}, {61'd0, res});
      chk({tag, " pa"}, {32'd0, lk_pa}, {32'd0, pa});
      @(posedge clk);
      #1 lk_req = 1'b0;
   endtask

   task automatic peek(input int idx);
      rd_idx = 4'(idx);
      #1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog act=running exp=done");
      report();
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      for (int i = 0; i < 16; i++) begin
         peek(i);
         chk("R1 slot empty", {63'd0, rd_inuse}, 64'd0);
      end
      lookup("R1 empty lookup", 32'h00010ABC, 8'd1, 2'd0, O_MISS, 32'h0);

      // setup, slots 0..5 (R8 lowest empty)
      refill(20'h00010, 8'd1, 20'h80240, 3'd0, 1'b1, 2'd2);
      refill(20'h00020, 8'd1, 20'h00300, 3'd0, 1'b1, 2'd0);
      refill(20'h00030, 8'd1, 20'h00400, 3'd0, 1'b1, 2'd1);
      refill(20'h00005, 8'd2, 20'h80243, 3'd2, 1'b1, 2'd2); // low bits ignored (R4)
      refill(20'h00040, 8'd1, 20'h00500, 3'd0, 1'b0, 2'd2);
      refill(20'h00010, 8'd3, 20'h00600, 3'd0, 1'b1, 2'd2);
      peek(3);
      chk("R8 fill order slot3", {44'd0, rd_vpn}, 64'h5);

      // vector table
      for (int v = 0; v < NV; v++) begin
         lookup($sformatf("vec%0d R2/R3/R4/R5/R6", v), VECS[v].va, VECS[v].asid,
                VECS[v].acc, VECS[v].res, VECS[v].pa);
      end

      // R7 flags
      peek(0); chk("R7 slot0 ref", {62'd0, rd_ref, rd_mod}, 64'b10);
      peek(1); chk("R7 slot1 fault no mod", {62'd0, rd_ref, rd_mod}, 64'b10);
      peek(3); chk("R7 slot3 write", {62'd0, rd_ref, rd_mod}, 64'b11);
      peek(4); chk("R7 invalid untouched", {62'd0, rd_ref, rd_mod}, 64'b00);
      peek(5); chk("R7 slot5 write", {62'd0, rd_ref, rd_mod}, 64'b11);

      // R12 no request
      @(negedge clk);
      lk_va = 32'h00006234; lk_asid = 8'd2; lk_acc = 2'd0; lk_req = 1'b0;
      #2 chk("R12 quiet", {60'd0, lk_hit, lk_miss, lk_fault, lk_multi}, 64'd0);

      // R11 multi-hit
      refill(20'h00010, 8'd1, 20'h11111, 3'd0, 1'b1, 2'd2);  // slot 6
      @(negedge clk);
      lk_va = 32'h00010ABC; lk_asid = 8'd1; lk_acc = 2'd0; lk_req = 1'b1;
      #2;
      chk("R11 multi flag", {63'd0, lk_multi}, 64'd1);
      chk("R11 lowest wins", {32'd0, lk_pa}, {32'd0, 32'h80240ABC});
      @(posedge clk);
      #1 lk_req = 1'b0;

      // R8 fill 7..15, then round robin
      for (int i = 7; i < 16; i++) refill(20'h00100 + 20'(i), 8'd7, 20'h00900, 3'd0, 1'b1, 2'd2);
      peek(15); chk("R8 last empty slot", {44'd0, rd_vpn}, 64'h10F);
      refill(20'h00200, 8'd9, 20'h00A00, 3'd0, 1'b1, 2'd2);
      refill(20'h00201, 8'd9, 20'h00A01, 3'd0, 1'b1, 2'd2);
      peek(0); chk("R8 rr slot0", {44'd0, rd_vpn}, 64'h200);
      peek(1); chk("R8 rr slot1", {44'd0, rd_vpn}, 64'h201);

      // R13 hit and refill on the same slot (rr now at 2)
      @(negedge clk);
      lk_va = 32'h00030F00; lk_asid = 8'd1; lk_acc = 2'd2; lk_req = 1'b1;
      wr_vpn = 20'h00300; wr_asid = 8'd1; wr_ppn = 20'h00B00; wr_size = 3'd0;
      wr_valid = 1'b1; wr_prot = 2'd2; wr_en = 1'b1;
      #2;
      chk("R13 old answer", {31'd0, lk_hit, lk_pa}, {31'd0, 1'b1, 32'h00400F00});
      @(posedge clk);
      #1 begin lk_req = 1'b0; wr_en = 1'b0; end
      peek(2);
      chk("R13 new tag", {44'd0, rd_vpn}, 64'h300);
      chk("R13 flags clear", {62'd0, rd_ref, rd_mod}, 64'd0);

      // R10 address-space flush with a refill dropped
      @(negedge clk);
      flush_asid_id = 8'd7; flush_asid_en = 1'b1;
      wr_vpn = 20'h00777; wr_asid = 8'd1; wr_en = 1'b1;
      @(negedge clk);
      flush_asid_en = 1'b0; wr_en = 1'b0;
      peek(7);  chk("R10 asid7 slot7 empty", {63'd0, rd_inuse}, 64'd0);
      peek(15); chk("R10 asid7 slot15 empty", {63'd0, rd_inuse}, 64'd0);
      peek(3);  chk("R10 other space kept", {63'd0, rd_inuse}, 64'd1);
      lookup("R10 flushed miss", 32'h00107000, 8'd7, 2'd0, O_MISS, 32'h0);
      lookup("R10 dropped refill", 32'h00777000, 8'd1, 2'd0, O_MISS, 32'h0);
      lookup("R10 kept superpage", 32'h00006234, 8'd2, 2'd1, O_HIT, 32'h80242234);
      refill(20'h00123, 8'd4, 20'h00C00, 3'd0, 1'b1, 2'd2);
      peek(7); chk("R8 reuse lowest empty", {44'd0, rd_vpn}, 64'h123);

      // R9 full flush beats refill
      @(negedge clk);
      flush_all = 1'b1; wr_vpn = 20'h00888; wr_asid = 8'd1; wr_en = 1'b1;
      @(negedge clk);
      flush_all = 1'b0; wr_en = 1'b0;
      begin
         int live = 0;
         for (int i = 0; i < 16; i++) begin
            peek(i);
            live += int'(rd_inuse);
         end
         chk("R9 all empty", 64'(live), 64'd0);
      end
      lookup("R9 dropped refill", 32'h00888000, 8'd1, 2'd0, O_MISS, 32'h0);

      report();
      $finish;
   end
endmodule